// File: doc/BRIEF.md
# Dual-Mode Converter Result Serial Port

This block takes a finished conversion result and shifts it out, most significant bit first, over a serial data line. It can clock the transfer in two ways, chosen by a mode pin that is held steady during a transfer. In self-clocked mode the port generates its own serial clock from the master clock. In external-clock mode a host drives the serial clock, and the port follows its edges after bringing them into the master-clock domain. An active-low chip select gates every transfer. When the port is not sending, the data and clock pins are released, and each of them carries an output-enable that models the high-impedance state.

A one-cycle load strobe writes a new raw result, and the word is coded as it is captured. Unipolar results are passed through as straight binary. Bipolar results are moved to offset binary, and both codings clamp at the ends of the output range. A data-ready flag, active low, marks an unread word. It returns high when the last bit has been shifted out. A newer load replaces a word that was never read.

Top module: `ser_result_port`

## Requirements
- R1: During and right after reset, data-ready is high (no word pending) and both the data enable and the clock enable are low.
- R2: A load strobe captures the coded word, and data-ready is low on the next clock. A later load replaces any unread or partly sent word, and a transfer that follows sends only the newest word.
- R3: With the bipolar input low, the raw signed result (DATA_W+1 bits) is sent as straight binary. A negative raw value is sent as all zeros.
- R4: With the bipolar input high, the sent word is raw + 2^(DATA_W-1) (0x80000 for 20 bits). Sums below zero send all zeros, and sums above 2^DATA_W-1 send all ones.
- R5: In self-clocked mode (ext_mode = 0), with chip select already low, the data enable rises and the MSB is driven two master clocks after data-ready falls. The first serial-clock rise comes one master clock later. The serial clock is high for one master clock and low for one master clock. The data bit changes only in the master clock in which the serial clock falls, and bits go out MSB first.
- R6: In self-clocked mode, one master clock after the serial-clock rise that carries the LSB, the data and clock enables drop and data-ready returns high.
- R7: In external-clock mode (ext_mode = 1), the clock enable stays low. Chip select and the serial clock input each pass through a two-flop synchronizer. Each detected falling edge moves on to the next bit, MSB first. The falling edge after the LSB drops the data enable and sets data-ready high.
- R8: In external-clock mode, a falling serial-clock edge that comes before any rising edge in the transfer is ignored, so the MSB stays on the line.
- R9: If chip select rises in the middle of a word, the current bit is completed and then the outputs float. In self-clocked mode the bit ends at the end of its high phase. In external-clock mode it ends at the next host falling edge. Data-ready stays low. When chip select is asserted again, the transfer restarts from the MSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 0: self-clocked, 1: host-supplied serial clock; static during a transfer |
| bipolar | input | 1 | 1: offset-binary coding, 0: straight binary |
| load | input | 1 | One-cycle strobe marking a new raw result |
| raw_result | input | DATA_W+1 | Signed raw result from the filter |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| sclk_in | input | 1 | Host serial clock (external-clock mode) |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Drive enable for sdata; low means high impedance |
| sclk_out | output | 1 | Generated serial clock (self-clocked mode) |
| sclk_oe | output | 1 | Drive enable for sclk_out; low means high impedance |
| drdy_n | output | 1 | Active-low data-ready |

## Verification
The assertions assume that ext_mode changes only while no transfer is active. They also assume that load is a single-cycle strobe of a settled raw value. The stimulus changes the mode only between scenarios, after the outputs have floated. In external-clock mode the host clock phases last six master clocks, long enough for the synchronizers to resolve. The stimulus pulses load for exactly one cycle.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_SC_LEAD,
        ST_SC_HIGH,
        ST_SC_LOW,
        ST_EX_ACT
    } port_state_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } clk_edge_t;

    function automatic clk_edge_t detect_edge(input logic now_v, input logic prev_v);
        clk_edge_t e;
        e.rise = now_v & ~prev_v;
        e.fall = ~now_v & prev_v;
        return e;
    endfunction

endpackage

// File: rtl/sync_stage.sv
module sync_stage #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] r;

    always_ff @(posedge clk) begin
        if (rst) r <= {STAGES{RST_VAL}};
        else     r <= {r[STAGES-2:0], d};
    end

    assign q = r[STAGES-1];
endmodule

// File: rtl/result_coder.sv
module result_coder #(
    parameter int DATA_W = 20
) (
    input  logic signed [DATA_W:0]   raw,
    input  logic                     bip,
    output logic        [DATA_W-1:0] code
);
    localparam logic signed [DATA_W+1:0] HALF = (DATA_W+2)'(2**(DATA_W-1));
    localparam logic signed [DATA_W+1:0] MAXV = (DATA_W+2)'(2**DATA_W - 1);

    logic signed [DATA_W+1:0] wide;
    logic signed [DATA_W+1:0] sum;

    always_comb begin
        wide = {raw[DATA_W], raw};
        sum  = bip ? (wide + HALF) : wide;
        if (sum[DATA_W+1])   code = '0;
        else if (sum > MAXV) code = '1;
        else                 code = sum[DATA_W-1:0];
    end
endmodule

// File: rtl/ser_shift_ctrl.sv
module ser_shift_ctrl
    import ser_port_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_mode,
    input  logic              load,
    input  logic [DATA_W-1:0] code_in,
    input  logic              cs_low,
    input  logic              sclk_s,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              drdy_n
);
    localparam int             IDX_W    = $clog2(DATA_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    port_state_t       st;
    logic [DATA_W-1:0] word_q;
    logic [IDX_W-1:0]  idx;
    logic              armed;
    logic              sclk_d;
    logic              drdy_q;
    clk_edge_t         hedge;

    assign hedge = detect_edge(sclk_s, sclk_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            word_q <= '0;
            idx    <= IDX_LAST;
            armed  <= 1'b0;
            sclk_d <= 1'b0;
            drdy_q <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            if (load) begin
                word_q <= code_in;
                idx    <= IDX_LAST;
                drdy_q <= 1'b0;
                armed  <= 1'b0;
                st     <= ST_IDLE;
            end else begin
                case (st)
                    ST_IDLE: begin
                        idx <= IDX_LAST;
                        if (!drdy_q && cs_low) st <= ST_START;
                    end
                    ST_START: begin
                        armed <= 1'b0;
                        st    <= ext_mode ? ST_EX_ACT : ST_SC_LEAD;
                    end
                    ST_SC_LEAD: st <= ST_SC_HIGH;
                    ST_SC_HIGH: begin
                        if (idx == '0) begin
                            st     <= ST_IDLE;
                            drdy_q <= 1'b1;
                        end else if (!cs_low) begin
                            st <= ST_IDLE;
                        end else begin
                            st  <= ST_SC_LOW;
                            idx <= idx - 1'b1;
                        end
                    end
                    ST_SC_LOW: st <= ST_SC_HIGH;
                    ST_EX_ACT: begin
                        if (!armed) begin
                            if (!cs_low)         st    <= ST_IDLE;
                            else if (hedge.rise) armed <= 1'b1;
                        end else if (hedge.fall) begin
                            if (idx == '0) begin
                                st     <= ST_IDLE;
                                drdy_q <= 1'b1;
                            end else if (!cs_low) begin
                                st <= ST_IDLE;
                            end else begin
                                idx <= idx - 1'b1;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        sdata_oe = (st == ST_SC_LEAD) || (st == ST_SC_HIGH) ||
                   (st == ST_SC_LOW)  || (st == ST_EX_ACT);
        sclk_oe  = (st == ST_SC_LEAD) || (st == ST_SC_HIGH) || (st == ST_SC_LOW);
        sclk_out = (st == ST_SC_HIGH);
        sdata    = sdata_oe ? word_q[idx] : 1'b0;
        drdy_n   = drdy_q;
    end
endmodule

// File: rtl/ser_result_port.sv
module ser_result_port #(
    parameter int DATA_W    = 20,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_mode,
    input  logic              bipolar,
    input  logic              load,
    input  logic [DATA_W:0]   raw_result,
    input  logic              cs_n,
    input  logic              sclk_in,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              drdy_n
);
    logic              cs_q;
    logic              sclk_q;
    logic [DATA_W-1:0] code;

    sync_stage #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) i_cs_sync (
        .clk(clk), .rst(rst), .d(cs_n), .q(cs_q)
    );

    sync_stage #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b0)) i_sclk_sync (
        .clk(clk), .rst(rst), .d(sclk_in), .q(sclk_q)
    );

    result_coder #(.DATA_W(DATA_W)) i_coder (
        .raw(raw_result), .bip(bipolar), .code(code)
    );

    ser_shift_ctrl #(.DATA_W(DATA_W)) i_ctrl (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .load(load),
        .code_in(code), .cs_low(~cs_q), .sclk_s(sclk_q),
        .sdata(sdata), .sdata_oe(sdata_oe), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .drdy_n(drdy_n)
    );
endmodule

// File: rtl/ser_result_port_chk.sv
module ser_result_port_chk (
    input logic clk,
    input logic rst,
    input logic ext_mode,
    input logic load,
    input logic sdata,
    input logic sdata_oe,
    input logic sclk_out,
    input logic sclk_oe,
    input logic drdy_n
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (drdy_n && !sdata_oe && !sclk_oe));

    assert_load_ready_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> !drdy_n);

    assert_sc_high_once_R5: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && sclk_out) |=> !sclk_out);

    assert_sc_bit_held_R5: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && sclk_out) |-> $stable(sdata));

    assert_float_at_done_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(drdy_n) |-> (!sdata_oe && !sclk_oe));

    assert_ext_no_clk_R7: assert property (@(posedge clk) disable iff (rst)
        ext_mode |-> !sclk_oe);
endmodule

bind ser_result_port ser_result_port_chk i_chk (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .load(load),
    .sdata(sdata), .sdata_oe(sdata_oe), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .drdy_n(drdy_n)
);

// File: tb/test_ser_result_port.sv
module test_ser_result_port;
    localparam int W = 20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ext_mode = 1'b0;
    logic         bipolar = 1'b0;
    logic         load = 1'b0;
    logic [W:0]   raw_result = '0;
    logic         cs_n = 1'b1;
    logic         sclk_in = 1'b0;
    logic         sdata, sdata_oe, sclk_out, sclk_oe, drdy_n;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ser_result_port #(.DATA_W(W)) i_ser_result_port (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .bipolar(bipolar),
        .load(load), .raw_result(raw_result), .cs_n(cs_n), .sclk_in(sclk_in),
        .sdata(sdata), .sdata_oe(sdata_oe), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .drdy_n(drdy_n)
    );

    function automatic logic [W-1:0] exp_code(input longint raw, input bit bip);
        longint v = raw + (bip ? 64'sd524288 : 64'sd0);
        if (v < 0) return '0;
        if (v > 64'sd1048575) return '1;
        return v[W-1:0];
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_load(input longint raw, input bit bip);
        raw_result = (W+1)'(raw);
        bipolar    = bip;
        load       = 1'b1;
        tick();
        load       = 1'b0;
    endtask

    // Self-clocked read; n counts negedges, n=1 right after the load edge
    task automatic sc_read(output logic [W-1:0] word, output int nbits,
                           output int first_oe, output int first_rise, output bit dbl);
        int  n = 1;
        bit  prev = 1'b0;
        bit  started = 1'b0;
        word = '0; nbits = 0; first_oe = -1; first_rise = -1; dbl = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (sdata_oe && first_oe < 0) first_oe = n;
            if (sclk_out && !prev) begin
                if (first_rise < 0) first_rise = n;
                word = {word[W-2:0], sdata};
                nbits++;
            end
            if (sclk_out && prev) dbl = 1'b1;
            if (started && !sdata_oe) break;
            started = started | sdata_oe;
            prev = sclk_out;
            tick();
            n++;
        end
    endtask

    task automatic ext_read(output logic [W-1:0] word, output bit oe_lost);
        word = '0; oe_lost = 1'b0;
        for (int k = 0; k < W; k++) begin
            repeat (6) tick();
            if (!sdata_oe) oe_lost = 1'b1;
            word = {word[W-2:0], sdata};
            sclk_in = 1'b1;
            repeat (6) tick();
            sclk_in = 1'b0;
        end
        repeat (6) tick();
    endtask

    task automatic t_reset();
        check(drdy_n === 1'b1, "R1 drdy_n", drdy_n, 1);
        check(sdata_oe === 1'b0 && sclk_oe === 1'b0, "R1 enables", {sdata_oe, sclk_oe}, 0);
    endtask

    task automatic t_sc_word(input longint raw, input bit bip, input string req);
        logic [W-1:0] w; int nb, fo, fr; bit dbl;
        ext_mode = 1'b0; cs_n = 1'b0;
        repeat (4) tick();
        do_load(raw, bip);
        check(drdy_n === 1'b0, "R2 drdy after load", drdy_n, 0);
        sc_read(w, nb, fo, fr, dbl);
        check(w === exp_code(raw, bip), req, w, exp_code(raw, bip));
        check(nb == W, "R5 bit count", nb, W);
        check(fo == 3, "R5 MSB delay", fo, 3);
        check(fr == 4, "R5 first rise", fr, 4);
        check(!dbl, "R5 one-cycle high", dbl, 0);
        check(drdy_n === 1'b1 && sclk_oe === 1'b0, "R6 end float", {drdy_n, sclk_oe}, 2);
    endtask

    task automatic t_overwrite();
        logic [W-1:0] w; int nb, fo, fr; bit dbl;
        ext_mode = 1'b0; cs_n = 1'b1;
        repeat (4) tick();
        do_load(64'h11111, 1'b0);
        repeat (3) tick();
        do_load(64'h5A5A5, 1'b0);
        check(drdy_n === 1'b0, "R2 drdy pending", drdy_n, 0);
        cs_n = 1'b0;
        sc_read(w, nb, fo, fr, dbl);
        check(w === 20'h5A5A5, "R2 newest word", w, 20'h5A5A5);
    endtask

    task automatic t_sc_abort();
        logic [W-1:0] w; int nb, fo, fr, rises; bit dbl, prev;
        ext_mode = 1'b0; cs_n = 1'b0;
        repeat (4) tick();
        do_load(64'hC3C3C, 1'b0);
        rises = 0; prev = 1'b0;
        for (int k = 0; k < 100 && rises < 3; k++) begin
            if (sclk_out && !prev) rises++;
            prev = sclk_out;
            tick();
        end
        cs_n = 1'b1;
        repeat (12) tick();
        check(sdata_oe === 1'b0 && sclk_oe === 1'b0, "R9 sc float", {sdata_oe, sclk_oe}, 0);
        check(drdy_n === 1'b0, "R9 sc word kept", drdy_n, 0);
        cs_n = 1'b0;
        sc_read(w, nb, fo, fr, dbl);
        check(w === 20'hC3C3C && nb == W, "R9 sc restart", w, 20'hC3C3C);
    endtask

    task automatic t_ext_read();
        logic [W-1:0] w; bit lost;
        ext_mode = 1'b1; sclk_in = 1'b0; cs_n = 1'b0;
        repeat (4) tick();
        do_load(64'h6D2B9, 1'b0);
        repeat (2) tick();
        ext_read(w, lost);
        check(w === 20'h6D2B9, "R7 ext word", w, 20'h6D2B9);
        check(!lost, "R7 oe during word", lost, 0);
        check(sdata_oe === 1'b0 && drdy_n === 1'b1 && sclk_oe === 1'b0,
              "R7 ext end", {sdata_oe, drdy_n, sclk_oe}, 2);
    endtask

    task automatic t_ext_arm();
        logic [W-1:0] w; bit lost;
        ext_mode = 1'b1; sclk_in = 1'b1; cs_n = 1'b0;
        repeat (4) tick();
        do_load(64'hA1234, 1'b0);
        repeat (8) tick();
        sclk_in = 1'b0;
        repeat (8) tick();
        check(sdata_oe === 1'b1 && sdata === 1'b1, "R8 MSB held", sdata, 1);
        ext_read(w, lost);
        check(w === 20'hA1234, "R8 full word", w, 20'hA1234);
    endtask

    task automatic t_ext_abort();
        logic [W-1:0] w; bit lost;
        ext_mode = 1'b1; sclk_in = 1'b0; cs_n = 1'b0;
        repeat (4) tick();
        do_load(64'h3F0F1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            repeat (6) tick();
            sclk_in = 1'b1;
            repeat (6) tick();
            sclk_in = 1'b0;
        end
        repeat (6) tick();
        cs_n = 1'b1;
        repeat (6) tick();
        check(sdata_oe === 1'b1, "R9 ext bit held", sdata_oe, 1);
        sclk_in = 1'b1;
        repeat (6) tick();
        sclk_in = 1'b0;
        repeat (6) tick();
        check(sdata_oe === 1'b0 && drdy_n === 1'b0, "R9 ext float", {sdata_oe, drdy_n}, 0);
        cs_n = 1'b0;
        repeat (8) tick();
        ext_read(w, lost);
        check(w === 20'h3F0F1, "R9 ext restart", w, 20'h3F0F1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        t_reset();
        rst = 1'b0;
        tick();
        t_reset();
        t_sc_word(64'hABCDE, 1'b0, "R3 unipolar");
        t_sc_word(-64'sd5, 1'b0, "R3 negative to zero");
        t_sc_word(64'sd0, 1'b1, "R4 bipolar zero");
        t_sc_word(64'h12345, 1'b1, "R4 bipolar positive");
        t_sc_word(64'h7FFFF, 1'b1, "R4 bipolar top");
        t_sc_word(64'h90000, 1'b1, "R4 bipolar clamp high");
        t_sc_word(-64'sh90000, 1'b1, "R4 bipolar clamp low");
        t_sc_word(-64'sh80000, 1'b1, "R4 bipolar bottom");
        t_overwrite();
        t_sc_abort();
        t_ext_read();
        t_ext_arm();
        t_ext_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule